// File: doc/BRIEF.md
# External Interrupt Request Detector

This block turns a set of active-low external interrupt pins into pending request flags for a downstream interrupt controller. Each pin first passes through a multi-flop synchroniser. The synchronised value is then sampled once per machine cycle, and a one-clock strobe input marks each machine cycle. A mode bit for each channel selects how a request is recognised. In level mode, a low sample is a request. In falling-edge mode, a request needs a high sample followed by a low sample on the next machine cycle.

Each channel holds a pending flag, which drives its request output directly. The controller clears a flag by pulsing that channel's acknowledge when it vectors to the service routine. A host bus can overwrite all pending flags at once with a write strobe. In level mode the flag is not latched: every machine-cycle sample recomputes it from the pin. In edge mode the flag stays set until it is acknowledged or overwritten.

Top module: `extint_detect`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every request output is 0. The synchroniser and previous-sample registers reset to high, so a pin held high after reset produces no request.
- R2: In level mode (mode bit 0), on each machine-cycle strobe the pending flag becomes the inverse of the synchronised pin sample: 1 when the sample is low, 0 when it is high.
- R3: In edge mode (mode bit 1), a strobe whose sample is low, where the sample at the previous strobe was high, sets the pending flag to 1.
- R4: In edge mode, a strobe that does not see a falling edge leaves the pending flag unchanged. A pin that stays low therefore neither re-sets a cleared flag nor clears a set one.
- R5: An acknowledge on a channel clears its pending flag on the next clock edge. This holds whenever no hardware update of that channel happens on the same edge.
- R6: In level mode, if the pin is still low after an acknowledge has cleared the flag, the flag comes back to 1 at the next strobe.
- R7: A host write (write strobe high, one data bit per channel, bit n for channel n) loads the pending flags on the next clock edge. Acknowledge and any hardware update on the same edge override the written value for that channel.
- R8: If a hardware set lands on the same edge as an acknowledge or a host write of 0, the set wins and the flag is 1.
- R9: Pins are sampled only at strobes. A low pulse that starts and ends between two strobes, as seen after synchronisation, has no effect in either mode. Without a strobe, acknowledge or write, the flags hold.
- R10: A pin change applied before clock edge k is visible to a strobe at edge k+2. A strobe at edge k+1 still sees the old level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | One-clock machine-cycle sampling strobe |
| pin_n | input | NCH | Asynchronous active-low interrupt pins |
| mode_edge | input | NCH | Detection mode per channel: 0 level, 1 falling edge |
| ack | input | NCH | Controller acknowledge per channel, clears the pending flag |
| wr_en | input | 1 | Host write strobe for the pending flags |
| wr_data | input | NCH | Host write data, bit n for channel n |
| req | output | NCH | Pending request per channel |

## Verification
Directed cases test each behaviour on its own:
- A level channel acknowledged while its pin stays low, which separates a latched flag from a recomputed one.
- An edge channel held low across many strobes, which separates edge detection from level detection.
- A pulse that falls between two strobes, which exposes sampling at clock rate instead of machine-cycle rate.
- A strobe placed one and then two edges after a pin change, which measures the synchroniser depth.
- A falling edge that coincides with both an acknowledge and a host clear, which tests the priority order.

Random traffic then mixes all of these inputs on both channels and switches the modes. The bench compares every output against a model built from the requirements.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic {
        DET_LEVEL = 1'b0,
        DET_FALL  = 1'b1
    } det_mode_e;

    typedef enum logic [1:0] {
        UPD_HOLD,
        UPD_HW,
        UPD_ACK,
        UPD_WR
    } upd_src_e;

    typedef struct packed {
        upd_src_e src;
        logic     val;
    } pend_upd_s;

    // Hardware decision for one strobe: does this sample drive the flag, and to what value
    function automatic pend_upd_s hw_decide(det_mode_e mode, logic prev_hi, logic cur_hi);
        pend_upd_s u;
        u.src = UPD_HOLD;
        u.val = 1'b0;
        if (mode == DET_LEVEL) begin
            u.src = UPD_HW;
            u.val = ~cur_hi;
        end else if (prev_hi && !cur_hi) begin
            u.src = UPD_HW;
            u.val = 1'b1;
        end
        return u;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '1;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/extint_chan.sv
module extint_chan
    import extint_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      smp_hi,
    input  det_mode_e mode,
    input  logic      ack,
    input  logic      wr_en,
    input  logic      wr_bit,
    output logic      pend,
    output logic      prev_hi
);
    pend_upd_s hw_u;
    pend_upd_s upd;

    always_comb begin
        hw_u = hw_decide(mode, prev_hi, smp_hi);
        upd  = '{src: UPD_HOLD, val: pend};
        if (tick && hw_u.src == UPD_HW) upd = hw_u;
        else if (ack)                   upd = '{src: UPD_ACK, val: 1'b0};
        else if (wr_en)                 upd = '{src: UPD_WR,  val: wr_bit};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            prev_hi <= 1'b1;
        end else begin
            if (upd.src != UPD_HOLD) pend <= upd.val;
            if (tick)                prev_hi <= smp_hi;
        end
    end
endmodule

// File: rtl/extint_detect.sv
module extint_detect
    import extint_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           mc_tick,
    input  logic [NCH-1:0] pin_n,
    input  logic [NCH-1:0] mode_edge,
    input  logic [NCH-1:0] ack,
    input  logic           wr_en,
    input  logic [NCH-1:0] wr_data,
    output logic [NCH-1:0] req
);
    logic [NCH-1:0] smp_q;
    logic [NCH-1:0] prev_q;

    extint_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_n),
        .q   (smp_q)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            extint_chan u_chan (
                .clk     (clk),
                .rst     (rst),
                .tick    (mc_tick),
                .smp_hi  (smp_q[c]),
                .mode    (det_mode_e'(mode_edge[c])),
                .ack     (ack[c]),
                .wr_en   (wr_en),
                .wr_bit  (wr_data[c]),
                .pend    (req[c]),
                .prev_hi (prev_q[c])
            );
        end
    endgenerate
endmodule

// File: rtl/extint_detect_chk.sv
module extint_detect_chk #(
    parameter int NCH = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           mc_tick,
    input logic [NCH-1:0] mode_edge,
    input logic [NCH-1:0] ack,
    input logic           wr_en,
    input logic [NCH-1:0] wr_data,
    input logic [NCH-1:0] smp_q,
    input logic [NCH-1:0] prev_q,
    input logic [NCH-1:0] req
);
    a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |-> req == '0);

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_a
            a_r2_level_tracks: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && mc_tick && !mode_edge[c]) |-> req[c] == !$past(smp_q[c]));

            a_r3_fall_sets: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && mc_tick && mode_edge[c] && prev_q[c] && !smp_q[c]) |-> req[c]);

            a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && ack[c] && !mc_tick) |-> !req[c]);

            a_r7_write_loads: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && wr_en && !ack[c] && !mc_tick) |-> req[c] == $past(wr_data[c]));

            a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
                $past(!rst && !mc_tick && !ack[c] && !wr_en) |-> $stable(req[c]));
        end
    endgenerate
endmodule

bind extint_detect extint_detect_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/extint_detect_bench.sv
module extint_detect_bench;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mc_tick = 1'b0;
    logic [NCH-1:0] pin_n = '1;
    logic [NCH-1:0] mode_edge = '0;
    logic [NCH-1:0] ack = '0;
    logic           wr_en = 1'b0;
    logic [NCH-1:0] wr_data = '0;
    logic [NCH-1:0] req;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // requirement model
    logic [NCH-1:0] m_s1, m_s2, m_prev, m_pend;
    string          m_tag [NCH];

    always #5 clk = ~clk;

    extint_detect #(.NCH(NCH), .SYNC_STAGES(2)) u_extint_detect (
        .clk(clk), .rst(rst), .mc_tick(mc_tick), .pin_n(pin_n),
        .mode_edge(mode_edge), .ack(ack), .wr_en(wr_en),
        .wr_data(wr_data), .req(req)
    );

    task automatic check(string tag, logic act, logic exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
        end
    endtask

    // applies the inputs driven since the last negedge to the model
    task automatic model_update();
        for (int c = 0; c < NCH; c++) begin
            logic smp = m_s2[c];
            logic fall = m_prev[c] && !smp;
            logic swclr = ack[c] || (wr_en && !wr_data[c]);
            if (rst) begin
                m_pend[c] = 1'b0; m_tag[c] = "R1";
            end else if (mc_tick && !mode_edge[c]) begin
                m_pend[c] = !smp;
                m_tag[c] = (swclr && !smp) ? "R8" : "R2";
            end else if (mc_tick && fall) begin
                m_pend[c] = 1'b1;
                m_tag[c] = swclr ? "R8" : "R3";
            end else if (ack[c]) begin
                m_pend[c] = 1'b0; m_tag[c] = "R5";
            end else if (wr_en) begin
                m_pend[c] = wr_data[c]; m_tag[c] = "R7";
            end else begin
                m_tag[c] = mc_tick ? "R4" : "R9";
            end
            if (rst) m_prev[c] = 1'b1;
            else if (mc_tick) m_prev[c] = smp;
        end
        if (rst) begin m_s1 = '1; m_s2 = '1; end
        else begin m_s2 = m_s1; m_s1 = pin_n; end
    endtask

    task automatic step();
        @(negedge clk);
        model_update();
        for (int c = 0; c < NCH; c++)
            check(m_tag[c], req[c], m_pend[c], $sformatf("model ch%0d", c));
    endtask

    task automatic quiet(int n);
        mc_tick = 0; ack = '0; wr_en = 0;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            mc_tick = 1; step(); mc_tick = 0; step();
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        m_s1 = '1; m_s2 = '1; m_prev = '1; m_pend = '0;
        for (int i = 0; i < 3; i++) step();
        rst = 0;
        step();
        check("R1", req[0], 1'b0, "after reset ch0");
        check("R1", req[1], 1'b0, "after reset ch1");
        ticks(2);
        check("R1", req[0], 1'b0, "idle high ch0 level");

        // R10: synchroniser latency, ch0 level mode
        pin_n[0] = 0; step();
        mc_tick = 1; step();
        check("R10", req[0], 1'b0, "strobe one edge after change");
        step();
        check("R10", req[0], 1'b1, "strobe two edges after change");
        mc_tick = 0;

        // R6: level reasserts after acknowledge while pin low
        ack[0] = 1; step(); ack[0] = 0;
        check("R6", req[0], 1'b0, "cleared by ack");
        quiet(2);
        check("R6", req[0], 1'b0, "held between strobes");
        mc_tick = 1; step(); mc_tick = 0;
        check("R6", req[0], 1'b1, "reasserted at strobe");
        pin_n[0] = 1; quiet(3); ticks(1);
        check("R2", req[0], 1'b0, "level high clears");

        // R4: edge mode held low, ch1
        mode_edge[1] = 1; ticks(2);
        pin_n[1] = 0; quiet(3); ticks(1);
        check("R3", req[1], 1'b1, "falling edge sets");
        ticks(3);
        check("R4", req[1], 1'b1, "held while pin low");
        ack[1] = 1; step(); ack[1] = 0;
        check("R5", req[1], 1'b0, "edge ack clears");
        ticks(3);
        check("R4", req[1], 1'b0, "steady low no re-set");

        // R8: set wins over ack and host clear
        pin_n[1] = 1; quiet(3); ticks(1);
        pin_n[1] = 0; quiet(3);
        mc_tick = 1; ack[1] = 1; wr_en = 1; wr_data = '0; step();
        mc_tick = 0; ack = '0; wr_en = 0;
        check("R8", req[1], 1'b1, "set beats clear");

        // R7: host write both ways
        wr_en = 1; wr_data = 2'b01; step(); wr_en = 0;
        check("R7", req[0], 1'b1, "write 1 ch0");
        check("R7", req[1], 1'b0, "write 0 ch1");

        // R9: short pulse between strobes, both modes
        wr_en = 1; wr_data = '0; step(); wr_en = 0;
        pin_n = '1; mode_edge = 2'b10; quiet(3); ticks(1);
        pin_n = '0; step(); pin_n = '1; quiet(4);
        ticks(2);
        check("R9", req[0], 1'b0, "short pulse level");
        check("R9", req[1], 1'b0, "short pulse edge");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            mc_tick = ($urandom % 4) == 0;
            for (int c = 0; c < NCH; c++) begin
                if (($urandom % 8) == 0) pin_n[c] = ~pin_n[c];
                if (($urandom % 200) == 0) mode_edge[c] = ~mode_edge[c];
                ack[c] = ($urandom % 16) == 0;
            end
            wr_en = ($urandom % 16) == 0;
            wr_data = NCH'($urandom);
            step();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule